// File: doc/BRIEF.md
# NAND Flash Prefetch / Postwrite Engine

This block moves bytes between a 64-entry host FIFO and the 8-bit data bus of a NAND flash device. It works in one of two directions. In postwrite mode the host pushes bytes into the FIFO, and the engine sends each one to the flash with a write strobe. In prefetch mode the engine reads bytes from the flash with read strobes and places them in the FIFO, where the host pops them. A 16-bit transfer counter sets how many bytes move on the flash bus. The engine stops when the counter reaches zero.

Software uses a small register port to set the mode, the strobe length and the target device, to load the counter, and to mask and clear four sticky events. It also drives the chip-enable and write-protect pins of up to four devices directly. The four events are FIFO empty, FIFO full, counter at zero and flash ready. Each event passes through its mask bit, and the results are combined into one interrupt line. Command and address cycles, error correction and DMA arbitration are handled outside this block.

Top module: `nand_fifo_engine`

## Requirements
- R1: After reset all chip-enable pins are high, all write-protect pins are low, both strobes are high, `irq` is low, and the mask, status and counter registers read 0.
- R2: The register addresses are 0 CTRL, 1 COUNT, 2 MASK and 3 STATUS.
  - CTRL fields: chip-enables [3:0], write-protects [7:4], postwrite enable [8], prefetch enable [9], device select [11:10], strobe length [15:12].
  - MASK holds four bits. Bits 31:4 read as 0.
- R3: Each `nf_ce_n` and `nf_wp_n` pin follows its CTRL bit directly. A write-protect pin stays low until software writes a 1 to its bit.
- R4: In postwrite mode the engine sends FIFO bytes in push order on `nf_dout`, with `nf_we_n` low and `nf_dout_en` high. Each byte decrements COUNT by one. No strobe is issued while COUNT is 0.
- R5: In prefetch mode the engine starts a read strobe only while `nf_rb` is high. It samples `nf_din` in the last low cycle of the strobe, and the host pops the bytes in the order they were read.
- R6: Each strobe stays low for exactly the number of cycles in the CTRL length field, 1 to 15, where a field value of 0 counts as 1. At least one high cycle follows each strobe.
- R7: Prefetch pauses while the FIFO holds 64 bytes, and postwrite pauses while the FIFO is empty. Both resume without further software action.
- R8: While both enable bits are set, no strobe starts and STATUS bit 4 (mode error) is set.
- R9: STATUS bits are sticky and cleared by writing 1 to them. The bits are:
  - bit 0: `nf_rb` rose
  - bit 1: COUNT decremented to 0
  - bit 2: FIFO became full
  - bit 3: FIFO became empty
- R10: `irq` is the OR of STATUS[3:0] ANDed with MASK[3:0]. A mask bit of 0 blocks its event.
- R11: No strobe is issued while the chip-enable bit of the selected device is 1. Setting that bit during a strobe aborts the strobe: no byte moves and COUNT is unchanged.
- R12: A host push is ignored unless only postwrite is enabled. A host pop is ignored unless only prefetch is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_push | input | 1 | Host pushes `host_wdata` into the FIFO |
| host_wdata | input | 8 | Host write byte |
| host_pop | input | 1 | Host pops the FIFO head |
| host_rdata | output | 8 | FIFO head byte |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_full | output | 1 | FIFO holds 64 bytes |
| nf_din | input | 8 | Flash data in |
| nf_dout | output | 8 | Flash data out |
| nf_dout_en | output | 1 | Drive enable for `nf_dout` |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_rb | input | 1 | Flash ready (high) / busy (low) |
| nf_ce_n | output | 4 | Chip enables, active low |
| nf_wp_n | output | 4 | Write protects, active low |
| irq | output | 1 | Masked event output |

## Verification
The hardest case to reach is the mid-strobe abort. The chip-enable bit must rise while a strobe is still low, and nothing visible at the ports may change except the strobe returning high. To get there, the stimulus sets the longest strobe length and starts a single-byte postwrite. A few cycles into the strobe it writes CTRL to raise the chip-enable bit. It then checks that COUNT and the pending byte are untouched, lowers the chip-enable bit again, and checks that the same byte is delivered intact. The stall on a full FIFO is reached by reading 70 bytes in prefetch mode without popping any, so that the engine halts after 64 bytes with 6 still counted.

// File: rtl/nand_fifo_engine.sv
module nand_fifo_engine #(
  parameter int DEPTH_LOG2 = 6,
  parameter int N_DEV      = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             host_push,
  input  logic [7:0]       host_wdata,
  input  logic             host_pop,
  output logic [7:0]       host_rdata,
  output logic             fifo_empty,
  output logic             fifo_full,
  input  logic [7:0]       nf_din,
  output logic [7:0]       nf_dout,
  output logic             nf_dout_en,
  output logic             nf_re_n,
  output logic             nf_we_n,
  input  logic             nf_rb,
  output logic [N_DEV-1:0] nf_ce_n,
  output logic [N_DEV-1:0] nf_wp_n,
  output logic             irq
);
  localparam int DEPTH  = 1 << DEPTH_LOG2;
  localparam int SEL_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int WP_LO  = N_DEV;
  localparam int PW_B   = 2 * N_DEV;
  localparam int PF_B   = 2 * N_DEV + 1;
  localparam int SEL_LO = 2 * N_DEV + 2;
  localparam int WID_LO = SEL_LO + SEL_W;
  localparam int CTRL_W = WID_LO + 4;
  localparam logic [DEPTH_LOG2:0] FULL_LVL = DEPTH_LOG2'(0) | (DEPTH_LOG2+1)'(DEPTH);

  logic [N_DEV-1:0] ce_q, wp_q;
  logic             pw_q, pf_q;
  logic [SEL_W-1:0] sel_q;
  logic [3:0]       wid_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       mask_q;
  logic [4:0]       stat_q;
  logic             rb_q;

  logic [7:0]            mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
  logic [DEPTH_LOG2:0]   lvl, lvl_nxt;

  logic       busy, dir_rd;
  logic [3:0] timer;

  logic wr_ctrl, wr_cnt, wr_mask, wr_stat;
  assign wr_ctrl = reg_we && reg_addr == 2'd0;
  assign wr_cnt  = reg_we && reg_addr == 2'd1;
  assign wr_mask = reg_we && reg_addr == 2'd2;
  assign wr_stat = reg_we && reg_addr == 2'd3;

  logic unused_hi;
  assign unused_hi = ^reg_wdata[31:CTRL_W];

  logic mode_pw, mode_pf, ce_off;
  logic [3:0] wdt;
  assign mode_pw = pw_q & ~pf_q;
  assign mode_pf = pf_q & ~pw_q;
  assign ce_off  = ce_q[sel_q];
  assign wdt     = (wid_q == 4'd0) ? 4'd1 : wid_q;

  assign fifo_empty = (lvl == '0);
  assign fifo_full  = (lvl == FULL_LVL);

  logic done, eng_push, eng_pop, host_push_ok, host_pop_ok, do_push, do_pop, start, dec;
  assign done     = busy & ~ce_off & (timer == 4'd0);
  assign eng_push = done & dir_rd & ~fifo_full;
  assign eng_pop  = done & ~dir_rd & ~fifo_empty;
  assign host_push_ok = host_push & mode_pw & ~fifo_full & ~eng_push;
  assign host_pop_ok  = host_pop & mode_pf & ~fifo_empty & ~eng_pop;
  assign do_push  = eng_push | host_push_ok;
  assign do_pop   = eng_pop | host_pop_ok;
  assign dec      = eng_push | eng_pop;
  assign start    = ~busy & (cnt_q != '0) & ~ce_off &
                    (mode_pw ? ~fifo_empty : (mode_pf & ~fifo_full & nf_rb));

  assign lvl_nxt = lvl + (DEPTH_LOG2+1)'(do_push) - (DEPTH_LOG2+1)'(do_pop);

  // FIFO storage
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= eng_push ? nf_din : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      lvl <= lvl_nxt;
    end
  end

  assign host_rdata = mem[rd_ptr];
  assign nf_dout    = mem[rd_ptr];

  // Strobe sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dir_rd <= 1'b0;
      timer  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        dir_rd <= mode_pf;
        timer  <= wdt - 4'd1;
      end
    end else if (ce_off || timer == 4'd0) begin
      busy <= 1'b0;
    end else begin
      timer <= timer - 4'd1;
    end
  end

  assign nf_re_n    = ~(busy & dir_rd & ~ce_off);
  assign nf_we_n    = ~(busy & ~dir_rd & ~ce_off);
  assign nf_dout_en = ~nf_we_n;

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= '1;
      wp_q   <= '0;
      pw_q   <= 1'b0;
      pf_q   <= 1'b0;
      sel_q  <= '0;
      wid_q  <= 4'd1;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ce_q  <= reg_wdata[N_DEV-1:0];
        wp_q  <= reg_wdata[WP_LO +: N_DEV];
        pw_q  <= reg_wdata[PW_B];
        pf_q  <= reg_wdata[PF_B];
        sel_q <= reg_wdata[SEL_LO +: SEL_W];
        wid_q <= reg_wdata[WID_LO +: 4];
      end
      if (wr_mask) mask_q <= reg_wdata[3:0];
    end
  end

  assign nf_ce_n = ce_q;
  assign nf_wp_n = wp_q;

  // Transfer counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (wr_cnt)               cnt_q <= reg_wdata[CNT_W-1:0];
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // Events
  logic [4:0] ev_set, ev_clr;
  assign ev_set[0] = nf_rb & ~rb_q;
  assign ev_set[1] = dec & ~wr_cnt & (cnt_q == CNT_W'(1));
  assign ev_set[2] = (lvl_nxt == FULL_LVL) & ~fifo_full;
  assign ev_set[3] = (lvl_nxt == '0) & ~fifo_empty;
  assign ev_set[4] = pw_q & pf_q;
  assign ev_clr    = wr_stat ? reg_wdata[4:0] : 5'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rb_q   <= 1'b1;
    end else begin
      stat_q <= (stat_q & ~ev_clr) | ev_set;
      rb_q   <= nf_rb;
    end
  end

  assign irq = |(stat_q[3:0] & mask_q);

  logic [CTRL_W-1:0] ctrl_vec;
  assign ctrl_vec = {wid_q, sel_q, pf_q, pw_q, wp_q, ce_q};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(ctrl_vec);
      2'd1:    reg_rdata = 32'(cnt_q);
      2'd2:    reg_rdata = {28'd0, mask_q};
      default: reg_rdata = {27'd0, stat_q};
    endcase
  end

  // Checks
  logic [4:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_len <= '0;
    else        low_len <= (!nf_re_n || !nf_we_n) ? low_len + 5'd1 : 5'd0;
  end

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= FULL_LVL);

  assert_read_waits_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |-> $past(nf_rb));

  assert_conflict_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nf_re_n) || $fell(nf_we_n)) |-> !$past(pw_q && pf_q));

  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low_len <= 5'd15);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) && !$past(wr_cnt) |-> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: tb/test_nand_fifo_engine.sv
module test_nand_fifo_engine;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        host_push = 0, host_pop = 0;
  logic [7:0]  host_wdata = 0, host_rdata;
  logic        fifo_empty, fifo_full;
  logic [7:0]  nf_din = 0, nf_dout;
  logic        nf_dout_en, nf_re_n, nf_we_n, irq;
  logic        nf_rb = 0;
  logic [3:0]  nf_ce_n, nf_wp_n;

  nand_fifo_engine i_nand_fifo_engine (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .host_push, .host_wdata, .host_pop, .host_rdata, .fifo_empty, .fifo_full,
    .nf_din, .nf_dout, .nf_dout_en, .nf_re_n, .nf_we_n, .nf_rb,
    .nf_ce_n, .nf_wp_n, .irq);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] wq[$];
  logic [7:0] rq[$];
  int exp_w = 1, exp_rw = 1;
  int strobe_falls = 0;
  logic [7:0] fl_byte = 8'h11;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input logic [3:0] ce, input logic [3:0] wp,
                                       input bit pw, input bit pf, input logic [3:0] w);
    return {16'd0, w, 2'd0, pf, pw, wp, ce};
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_raw(input logic [7:0] b);
    @(negedge clk); host_push = 1; host_wdata = b;
    @(negedge clk); host_push = 0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    wq.push_back(b);
    push_raw(b);
  endtask

  task automatic pop_check(input string tag);
    logic [7:0] e;
    @(negedge clk);
    while (fifo_empty) @(negedge clk);
    e = (rq.size() > 0) ? rq.pop_front() : 8'hxx;
    chk(host_rdata === e, tag, host_rdata, e);
    host_pop = 1;
    @(negedge clk); host_pop = 0;
  endtask

  // flash model: new byte on every falling read strobe
  always @(negedge nf_re_n) begin
    nf_din <= fl_byte;
    rq.push_back(fl_byte);
    fl_byte = fl_byte + 8'd37;
  end

  // monitor: compares completed write strobes against the queue
  int wlow = 0, rlow = 0;
  logic [7:0] last_dout;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nf_we_n) begin
        if (wlow == 0) strobe_falls++;
        wlow++;
        last_dout = nf_dout;
        if (!nf_dout_en) chk(0, "R4 dout_en", 0, 1);
      end else if (wlow != 0) begin
        if (!nf_ce_n[0]) begin
          logic [7:0] e;
          e = (wq.size() > 0) ? wq.pop_front() : 8'hxx;
          chk(last_dout === e, "R4 write byte", last_dout, e);
          chk(wlow == exp_w, "R6 write strobe length", wlow, exp_w);
        end
        wlow = 0;
      end
      if (!nf_re_n) begin
        if (rlow == 0) strobe_falls++;
        rlow++;
      end else if (rlow != 0) begin
        chk(rlow == exp_rw, "R6 read strobe length", rlow, exp_rw);
        rlow = 0;
      end
    end
  end

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f0;
    idle(4); rst_n = 1; idle(2);

    // R1 reset state
    chk(nf_ce_n == 4'hF, "R1 ce_n", nf_ce_n, 4'hF);
    chk(nf_wp_n == 4'h0, "R1 wp_n", nf_wp_n, 0);
    chk(nf_re_n && nf_we_n && !irq, "R1 strobes/irq", {nf_re_n, nf_we_n, irq}, 3'b110);
    reg_rd(2, v); chk(v == 0, "R1 mask", v, 0);
    reg_rd(3, v); chk(v == 0, "R1 status", v, 0);
    reg_rd(1, v); chk(v == 0, "R1 count", v, 0);

    // R2 mask width
    reg_wr(2, 32'hFFFF_FFFF); reg_rd(2, v); chk(v == 32'hF, "R2 mask reserved", v, 32'hF);
    reg_wr(2, 0);

    // R3 pins follow control
    reg_wr(0, ctrl(4'b1010, 4'b0101, 0, 0, 1)); idle(1);
    chk(nf_ce_n == 4'hA, "R3 ce_n", nf_ce_n, 4'hA);
    chk(nf_wp_n == 4'h5, "R3 wp_n", nf_wp_n, 4'h5);
    reg_rd(0, v); chk(v[15:0] == 16'h1_05A, "R2 ctrl readback", v, 32'h105A);

    // R12 push ignored without a mode
    push_raw(8'hAA); push_raw(8'hBB); idle(1);
    chk(fifo_empty, "R12 push ignored idle", fifo_empty, 1);

    // R4 / R6 postwrite, length 3
    exp_w = 3;
    reg_wr(0, ctrl(4'b1110, 4'hF, 1, 0, 3));
    reg_wr(1, 5);
    push_byte(8'h3C); push_byte(8'hC3); push_byte(8'h00); push_byte(8'hFF); push_byte(8'h5A);
    idle(40);
    chk(wq.size() == 0, "R4 all bytes sent", wq.size(), 0);
    reg_rd(1, v); chk(v == 0, "R4 count drained", v, 0);
    reg_rd(3, v); chk((v & 32'hA) == 32'hA, "R9 cntzero+empty set", v, 32'hA);

    // R4 stop at zero
    f0 = strobe_falls;
    push_byte(8'h77); idle(20);
    chk(strobe_falls == f0, "R4 no strobe at zero", strobe_falls, f0);
    reg_wr(1, 1); idle(20);
    chk(wq.size() == 0, "R4 resume after load", wq.size(), 0);

    // R10 / R9 masking and clear
    chk(!irq, "R10 masked", irq, 0);
    reg_wr(2, 32'h2); idle(1);
    chk(irq, "R10 unmasked", irq, 1);
    reg_wr(3, 32'h2); idle(1);
    chk(!irq, "R9 cleared irq", irq, 0);
    reg_rd(3, v); chk((v & 32'hA) == 32'h8, "R9 w1c only bit1", v & 32'hA, 32'h8);
    reg_wr(2, 0);

    // R7 postwrite stall on empty
    reg_wr(1, 3);
    push_byte(8'h21); idle(20);
    reg_rd(1, v); chk(v == 2, "R7 stall on empty", v, 2);
    push_byte(8'h22); push_byte(8'h23); idle(30);
    chk(wq.size() == 0, "R7 resumed", wq.size(), 0);
    reg_rd(1, v); chk(v == 0, "R7 count zero", v, 0);

    // R11 ce high blocks; R12 pop ignored in postwrite
    reg_wr(0, ctrl(4'b1111, 4'hF, 1, 0, 3));
    reg_wr(1, 2);
    f0 = strobe_falls;
    push_byte(8'h91); push_byte(8'h92);
    @(negedge clk); host_pop = 1; @(negedge clk); host_pop = 0;
    idle(10);
    chk(strobe_falls == f0, "R11 no strobe ce high", strobe_falls, f0);
    reg_rd(1, v); chk(v == 2, "R11 count held", v, 2);
    reg_wr(0, ctrl(4'b1110, 4'hF, 1, 0, 3)); idle(30);
    chk(wq.size() == 0, "R12 pop ignored, order kept", wq.size(), 0);

    // R11 abort mid-strobe
    exp_w = 15;
    reg_wr(0, ctrl(4'b1110, 4'hF, 1, 0, 15));
    reg_wr(1, 1);
    push_byte(8'hE7); idle(5);
    chk(!nf_we_n, "R11 strobe in progress", nf_we_n, 0);
    reg_wr(0, ctrl(4'b1111, 4'hF, 1, 0, 15)); idle(20);
    reg_rd(1, v); chk(v == 1, "R11 abort keeps count", v, 1);
    chk(wq.size() == 1, "R11 abort keeps byte", wq.size(), 1);
    reg_wr(0, ctrl(4'b1110, 4'hF, 1, 0, 15)); idle(40);
    chk(wq.size() == 0, "R11 byte sent after abort", wq.size(), 0);
    reg_rd(1, v); chk(v == 0, "R11 count after retry", v, 0);

    // R8 mode conflict
    nf_rb = 1;
    reg_wr(0, ctrl(4'b1110, 4'hF, 1, 1, 1));
    reg_wr(1, 4);
    f0 = strobe_falls; idle(20);
    chk(strobe_falls == f0, "R8 no strobe", strobe_falls, f0);
    reg_rd(3, v); chk(v[4], "R8 error bit", v[4], 1);
    reg_wr(0, ctrl(4'b1110, 4'hF, 0, 0, 1));
    reg_wr(1, 0);
    reg_wr(3, 32'h1F); reg_rd(3, v); chk(v == 0, "R9 clear all", v, 0);

    // R5 prefetch waits for ready
    nf_rb = 0; idle(2);
    rq.delete();
    exp_rw = 1;
    reg_wr(0, ctrl(4'b1110, 4'hF, 0, 1, 0));
    reg_wr(1, 70);
    f0 = strobe_falls; idle(10);
    chk(strobe_falls == f0, "R5 waits for ready", strobe_falls, f0);
    nf_rb = 1; idle(2);
    reg_rd(3, v); chk(v[0], "R9 ready event", v[0], 1);

    // R7 stall on full
    idle(200);
    reg_rd(1, v); chk(v == 6, "R7 stall on full count", v, 6);
    chk(fifo_full, "R7 fifo full", fifo_full, 1);
    reg_rd(3, v); chk(v[2], "R9 full event", v[2], 1);
    for (int i = 0; i < 70; i++) pop_check("R5 prefetch byte");
    idle(10);
    chk(fifo_empty, "R5 drained", fifo_empty, 1);
    reg_rd(1, v); chk(v == 0, "R5 count zero", v, 0);

    // R12 push ignored in prefetch
    push_raw(8'h44); idle(1);
    chk(fifo_empty, "R12 push ignored prefetch", fifo_empty, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule